// File: doc/BRIEF.md
# ECC error event capture unit

This block sits beside a RAM port that has its own ECC checker. The checker raises one of two strobes on an access: one for a single-bit error it has corrected, and one for a multi-bit error it cannot correct. When the configuration enables that event type, the block records the access in one step. It keeps the address, the bus attributes (direction, transfer size, protection), the requesting master's ID and the data. It also raises a sticky status flag for that event type.

Software reaches the block through a small word-addressed register bus. Reads return data one cycle after the request. Register map, by word address: 0 is configuration (bit 0 enables corrected events, bit 1 enables non-correctable events, read/write). 1 is status (bit 0 corrected flag, bit 1 non-correctable flag, write 1 to clear). 2 is captured address, 3 is captured attributes, 4 is captured master ID and 5 is captured data, all read-only. Every other address reads zero. The ECC coding and the RAM are outside this block.

Top module: `ecc_event_capture`

## Requirements
- R1: After reset, the configuration, both flags and all capture registers are zero, and `reg_rdata_o` is zero.
- R2: A strobe whose enable bit is clear leaves every capture register and both flags unchanged.
- R3: An enabled event loads address, attributes, master ID and data together at the same clock edge, replacing earlier values, so the registers always show the most recent enabled event. After a non-correctable event the data register holds no defined value.
- R4: The attribute register (word 3, bits 7:0) holds the write flag in bit 7 (1 write, 0 read). It holds the size code in bits 6:4 (000 byte, 001 halfword, 010 word; codes 1xx are reserved and stored as given). It holds the four protection bits in bits 3:0, with bus protection bit n in bit n. In the MSB-first labelling, field positions 4 to 7 carry bus protection bits 3 down to 0.
- R5: An enabled corrected event sets status bit 0 and an enabled non-correctable event sets status bit 1. A flag stays set until software clears it.
- R6: Writing 1 to a status bit clears it and writing 0 leaves it. If an enabled event of that type arrives in the same cycle as the clear, the flag ends set.
- R7: When both strobes fire in the same cycle with both enables set, both flags are set, and the access is captured once.
- R8: Writes to the capture registers (words 2 to 5) and to reserved addresses change no state. Only bits 1:0 of a configuration write are kept.
- R9: A read request at one clock edge presents its data on `reg_rdata_o` after that edge. The output holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ram_addr_i | input | ADDR_W | Address of the RAM access |
| ram_write_i | input | 1 | Access direction, 1 = write |
| ram_size_i | input | 3 | Transfer size code |
| ram_prot_i | input | 4 | Bus protection bits |
| ram_mid_i | input | MID_W | Requesting master ID |
| ram_data_i | input | DATA_W | Access data |
| ev_corr_i | input | 1 | Corrected single-bit error strobe |
| ev_ncorr_i | input | 1 | Non-correctable error strobe |
| reg_req_i | input | 1 | Register bus request |
| reg_we_i | input | 1 | Register bus write enable |
| reg_addr_i | input | REG_AW | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, one cycle after request |

## Verification
Capture and flag state is visible only through the register bus. A wrong capture, a missed flag or a flag cleared when it should not be therefore shows on `reg_rdata_o` one cycle after the next read of that word. The bench reads back every register after each event. A disabled event that wrongly loads data, or a clear that loses to nothing, shows up on the very first read that follows it. Stale data after an overwrite shows up the same way.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;
  localparam int unsigned REG_DW = 32;

  typedef enum logic [2:0] {
    REG_CFG  = 3'd0,
    REG_STAT = 3'd1,
    REG_ADDR = 3'd2,
    REG_ATTR = 3'd3,
    REG_MID  = 3'd4,
    REG_DATA = 3'd5
  } reg_sel_e;

  typedef struct packed {
    logic       write;
    logic [2:0] size;
    logic [3:0] prot;
  } attr_t;
endpackage

// File: rtl/ecc_attr_pack.sv
module ecc_attr_pack
  import ecc_cap_pkg::*;
(
  input  logic       write_i,
  input  logic [2:0] size_i,
  input  logic [3:0] prot_i,
  output attr_t      attr_o
);
  localparam int unsigned PROT_N = 4;
  localparam int unsigned FIELD_W = 8;

  logic [PROT_N-1:0] prot_field;

  // MSB-first field position 4+j carries bus bit PROT_N-1-j
  for (genvar j = 0; j < PROT_N; j++) begin : g_prot
    localparam int unsigned POS_MSB0 = PROT_N + j;
    localparam int unsigned POS_LSB0 = FIELD_W - 1 - POS_MSB0;
    assign prot_field[POS_LSB0] = prot_i[PROT_N-1-j];
  end

  assign attr_o.write = write_i;
  assign attr_o.size  = size_i;
  assign attr_o.prot  = prot_field;
endmodule

// File: rtl/ecc_event_arb.sv
module ecc_event_arb (
  input  logic       ev_corr_i,
  input  logic       ev_ncorr_i,
  input  logic [1:0] cfg_en_i,
  output logic [1:0] set_o,
  output logic       cap_o
);
  assign set_o[0] = ev_corr_i  & cfg_en_i[0];
  assign set_o[1] = ev_ncorr_i & cfg_en_i[1];
  assign cap_o    = |set_o;
endmodule

// File: rtl/ecc_capture_regs.sv
module ecc_capture_regs
  import ecc_cap_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned MID_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  attr_t             attr_i,
  input  logic [MID_W-1:0]  mid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [ADDR_W-1:0] addr_o,
  output attr_t             attr_o,
  output logic [MID_W-1:0]  mid_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      attr_o <= '0;
      mid_o  <= '0;
      data_o <= '0;
    end else if (cap_i) begin
      addr_o <= addr_i;
      attr_o <= attr_i;
      mid_o  <= mid_i;
      data_o <= data_i;
    end
  end

  AST_HOLD_NO_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable({addr_o, attr_o, mid_o, data_o})); // R2
  AST_LOAD_TOGETHER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> (addr_o == $past(addr_i)) && (mid_o == $past(mid_i)) && (attr_o == $past(attr_i))); // R3
endmodule

// File: rtl/ecc_reg_if.sv
module ecc_reg_if
  import ecc_cap_pkg::*;
#(
  parameter int unsigned REG_AW = 4,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned MID_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [REG_DW-1:0] wdata_i,
  input  logic [1:0]        set_i,
  input  logic [ADDR_W-1:0] cap_addr_i,
  input  attr_t             cap_attr_i,
  input  logic [MID_W-1:0]  cap_mid_i,
  input  logic [DATA_W-1:0] cap_data_i,
  output logic [1:0]        cfg_en_o,
  output logic [1:0]        flags_o,
  output logic [REG_DW-1:0] rdata_o
);
  localparam logic [REG_AW-1:0] A_CFG  = REG_AW'(REG_CFG);
  localparam logic [REG_AW-1:0] A_STAT = REG_AW'(REG_STAT);
  localparam logic [REG_AW-1:0] A_ADDR = REG_AW'(REG_ADDR);
  localparam logic [REG_AW-1:0] A_ATTR = REG_AW'(REG_ATTR);
  localparam logic [REG_AW-1:0] A_MID  = REG_AW'(REG_MID);
  localparam logic [REG_AW-1:0] A_DATA = REG_AW'(REG_DATA);

  logic              wr, rd, cfg_wr, stat_wr;
  logic [1:0]        clr;
  logic [REG_DW-1:0] rd_mux;
  logic              unused_wdata;

  assign wr      = req_i & we_i;
  assign rd      = req_i & ~we_i;
  assign cfg_wr  = wr && (addr_i == A_CFG);
  assign stat_wr = wr && (addr_i == A_STAT);
  assign clr     = stat_wr ? wdata_i[1:0] : 2'b00;
  assign unused_wdata = ^wdata_i[REG_DW-1:2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_en_o <= '0;
      flags_o  <= '0;
    end else begin
      if (cfg_wr) cfg_en_o <= wdata_i[1:0];
      flags_o <= (flags_o & ~clr) | set_i;  // set beats clear
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      A_CFG:   rd_mux[1:0]        = cfg_en_o;
      A_STAT:  rd_mux[1:0]        = flags_o;
      A_ADDR:  rd_mux[ADDR_W-1:0] = cap_addr_i;
      A_ATTR:  rd_mux[7:0]        = cap_attr_i;
      A_MID:   rd_mux[MID_W-1:0]  = cap_mid_i;
      A_DATA:  rd_mux[DATA_W-1:0] = cap_data_i;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_o <= '0;
    else if (rd)  rdata_o <= rd_mux;
  end

  AST_FLAG_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == A_STAT && wdata_i[0] && !set_i[0]) |=> !flags_o[0]); // R6
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i[1] |=> flags_o[1]); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i && addr_i == A_STAT) |=> ((flags_o & $past(flags_o)) == $past(flags_o))); // R5
  AST_RO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i != A_CFG) |=> $stable(cfg_en_o)); // R8
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o)); // R9
endmodule

// File: rtl/ecc_event_capture.sv
module ecc_event_capture
  import ecc_cap_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned MID_W  = 4,
  parameter int unsigned REG_AW = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] ram_addr_i,
  input  logic              ram_write_i,
  input  logic [2:0]        ram_size_i,
  input  logic [3:0]        ram_prot_i,
  input  logic [MID_W-1:0]  ram_mid_i,
  input  logic [DATA_W-1:0] ram_data_i,
  input  logic              ev_corr_i,
  input  logic              ev_ncorr_i,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o
);
  attr_t             attr_now, attr_q;
  logic [1:0]        cfg_en, set, flags;
  logic              cap;
  logic [ADDR_W-1:0] addr_q;
  logic [MID_W-1:0]  mid_q;
  logic [DATA_W-1:0] data_q;

  ecc_attr_pack u_pack (
    .write_i (ram_write_i),
    .size_i  (ram_size_i),
    .prot_i  (ram_prot_i),
    .attr_o  (attr_now)
  );

  ecc_event_arb u_arb (
    .ev_corr_i  (ev_corr_i),
    .ev_ncorr_i (ev_ncorr_i),
    .cfg_en_i   (cfg_en),
    .set_o      (set),
    .cap_o      (cap)
  );

  ecc_capture_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MID_W(MID_W)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (cap),
    .addr_i (ram_addr_i),
    .attr_i (attr_now),
    .mid_i  (ram_mid_i),
    .data_i (ram_data_i),
    .addr_o (addr_q),
    .attr_o (attr_q),
    .mid_o  (mid_q),
    .data_o (data_q)
  );

  ecc_reg_if #(.REG_AW(REG_AW), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MID_W(MID_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (reg_req_i),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .set_i      (set),
    .cap_addr_i (addr_q),
    .cap_attr_i (attr_q),
    .cap_mid_i  (mid_q),
    .cap_data_i (data_q),
    .cfg_en_o   (cfg_en),
    .flags_o    (flags),
    .rdata_o    (reg_rdata_o)
  );

  AST_DISABLED_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags[1]) |-> $past(ev_ncorr_i && cfg_en[1])); // R2
  AST_DISABLED_NO_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(ev_corr_i && cfg_en[0]) && !(ev_ncorr_i && cfg_en[1])) |=> $stable(addr_q)); // R2
  AST_BOTH_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_corr_i && ev_ncorr_i && cfg_en == 2'b11) |=> (flags == 2'b11) && (mid_q == $past(ram_mid_i))); // R7
  AST_CORR_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_corr_i && cfg_en[0]) |=> flags[0]); // R5
endmodule

// File: tb/sim_ecc_event_capture.sv
module sim_ecc_event_capture;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ram_addr = '0;
  logic        ram_write = 1'b0;
  logic [2:0]  ram_size = '0;
  logic [3:0]  ram_prot = '0;
  logic [3:0]  ram_mid = '0;
  logic [31:0] ram_data = '0;
  logic        ev_corr = 1'b0, ev_ncorr = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [3:0]  raddr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  // reference model
  logic [1:0]  m_cfg = '0, m_flags = '0;
  logic [31:0] m_addr = '0, m_data = '0;
  logic [7:0]  m_attr = '0;
  logic [3:0]  m_mid = '0;
  bit          m_data_ok = 1'b1;

  always #(CLK_P/2) clk = ~clk;

  ecc_event_capture u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .ram_addr_i(ram_addr), .ram_write_i(ram_write), .ram_size_i(ram_size),
    .ram_prot_i(ram_prot), .ram_mid_i(ram_mid), .ram_data_i(ram_data),
    .ev_corr_i(ev_corr), .ev_ncorr_i(ev_ncorr),
    .reg_req_i(req), .reg_we_i(we), .reg_addr_i(raddr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; raddr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
    if (a == 0) m_cfg = d[1:0];
    if (a == 1) m_flags = m_flags & ~d[1:0];
  endtask

  task automatic reg_rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; raddr = a;
    @(negedge clk); req = 0; d = rdata;
  endtask

  task automatic fire(input bit c, input bit n, input logic [31:0] a, input bit w,
                      input logic [2:0] s, input logic [3:0] p, input logic [3:0] mid,
                      input logic [31:0] d);
    bit hc, hn;
    @(negedge clk);
    ram_addr = a; ram_write = w; ram_size = s; ram_prot = p; ram_mid = mid; ram_data = d;
    ev_corr = c; ev_ncorr = n;
    @(negedge clk); ev_corr = 0; ev_ncorr = 0;
    hc = c & m_cfg[0]; hn = n & m_cfg[1];
    if (hc || hn) begin
      m_addr = a; m_mid = mid; m_data = d; m_data_ok = !hn;
      m_attr = 8'(w * 128 + s * 16 + p);
    end
    m_flags = m_flags | {hn, hc};
  endtask

  task automatic check_all(input string tag);
    logic [31:0] v;
    reg_rd(0, v); chk(tag, v, {30'd0, m_cfg});
    reg_rd(1, v); chk(tag, v, {30'd0, m_flags});
    reg_rd(2, v); chk(tag, v, m_addr);
    reg_rd(3, v); chk(tag, v, {24'd0, m_attr});
    reg_rd(4, v); chk(tag, v, {28'd0, m_mid});
    if (m_data_ok) begin reg_rd(5, v); chk(tag, v, m_data); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    chk("R1 rdata", rdata, 32'd0);
    for (int a = 0; a < 16; a++) begin
      reg_rd(4'(a), v); chk("R1 reset regs", v, 32'd0);
    end

    // R2 R3 R5 R7: every enable combination against every strobe combination
    for (int en = 0; en < 4; en++) begin
      for (int ev = 0; ev < 4; ev++) begin
        reg_wr(1, 32'h3);
        reg_wr(0, 32'(en));
        fire(ev[0], ev[1], 32'h1000_0000 + 32'(en * 256 + ev * 16), ev[0], 3'(ev % 3),
             4'(en * 4 + ev), 4'(15 - en * 4 - ev), 32'hA500_0000 + 32'(en * 16 + ev));
        check_all(ev == 3 ? "R7 both strobes" : (en == 0 ? "R2 disabled" : "R3 R5 capture"));
      end
    end

    // R4: full attribute sweep, including reserved size codes
    reg_wr(0, 32'h1);
    for (int w = 0; w < 2; w++)
      for (int s = 0; s < 8; s++)
        for (int p = 0; p < 16; p++) begin
          fire(1, 0, 32'(w * 4096 + s * 16 + p), w[0], 3'(s), 4'(p), 4'(p), 32'(p * 7));
          reg_rd(3, v); chk("R4 attr", v, 32'(w * 128 + s * 16 + p));
        end
    check_all("R3 last event kept");

    // R5 sticky and R6 partial clear
    reg_wr(0, 32'h3);
    fire(1, 1, 32'hCAFE_0000, 1, 3'd2, 4'hF, 4'h3, 32'h1234_5678);
    reg_wr(1, 32'h0);
    reg_rd(1, v); chk("R5 sticky", v, 32'h3);
    reg_wr(1, 32'h1);
    reg_rd(1, v); chk("R6 clear bit0 only", v, 32'h2);

    // R6: corrected event in same cycle as clear of both flags
    @(negedge clk);
    ram_addr = 32'hBEEF_0004; ram_write = 0; ram_size = 3'd1; ram_prot = 4'h5;
    ram_mid = 4'h9; ram_data = 32'h0BAD_F00D; ev_corr = 1;
    req = 1; we = 1; raddr = 4'd1; wdata = 32'h3;
    @(negedge clk); ev_corr = 0; req = 0; we = 0;
    m_flags = 2'b01; m_addr = 32'hBEEF_0004; m_attr = 8'h15; m_mid = 4'h9;
    m_data = 32'h0BAD_F00D; m_data_ok = 1;
    check_all("R6 set wins");

    // R8: writes to read-only and reserved words
    for (int a = 2; a < 16; a++) reg_wr(4'(a), 32'hFFFF_FFFF);
    check_all("R8 ro writes");
    reg_wr(0, 32'hFFFF_FFFC);
    reg_rd(0, v); chk("R8 cfg mask", v, 32'h0);
    fire(1, 1, 32'h5555_5555, 1, 3'd0, 4'h1, 4'h1, 32'h1);
    check_all("R2 disabled after mask");

    // R9: output holds between reads, reserved reads zero
    reg_rd(2, v);
    repeat (3) @(negedge clk);
    chk("R9 hold", rdata, m_addr);
    reg_rd(4'd9, v); chk("R9 reserved read", v, 32'd0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule